// File: doc/BRIEF.md
# UART Receiver with Line Error Detection

This block turns an asynchronous serial input into bytes. A programmable divisor produces an oversampling tick, and sixteen ticks make one bit period. At run time the receiver is told the character width (5 to 8 bits), whether a parity bit is present and what sense it has, and whether one or two stop bits close each character. Each received character appears right-aligned on a byte output, together with a valid flag. The consumer clears that flag with a read pulse.

Four faults each set their own sticky flag: an unread byte that is overwritten (overrun), a parity mismatch, a missing stop bit (framing), and a line held low for longer than one whole character time (break). A single status-read pulse clears all four flags. The input passes through a two-flop synchroniser before any sampling. A falling edge is accepted as a start bit only if the line is still low half a bit later.

Top module: `uart_rx_err`

## Requirements
- R1: After reset, data_valid_o, overrun_o, parity_err_o, frame_err_o and break_o are all 0.
- R2: data_bits_i selects the character width: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Bits arrive least significant first. The byte on data_o is right-aligned with its unused upper bits at 0, and data_valid_o rises when the character completes.
- R3: When parity_en_i is 1, one parity bit follows the data bits. With parity_odd_i = 1 the data bits plus the parity bit must hold an odd number of ones; with parity_odd_i = 0 they must hold an even number. A mismatch sets parity_err_o.
- R4: two_stop_i = 1 expects two stop bits and 0 expects one. If any expected stop bit is sampled low, frame_err_o is set.
- R5: If a character completes while data_valid_o is still 1 and no read pulse arrives in that cycle, overrun_o is set and data_o takes the new byte.
- R6: break_o is set when the synchronised line stays low for more than 16 ticks times (1 + data bits + parity bit + stop bits). A character of all zeros with a valid stop bit does not set it.
- R7: A low pulse on rx_i that ends before the middle of the start bit is ignored. No byte is delivered and no flag is set.
- R8: All four error flags stay set until stat_rd_i is 1 on a clock edge. data_valid_o stays set until rd_data_i is 1 on a clock edge.
- R9: One bit period is 16 * (divisor_i + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| divisor_i | input | 16 | Tick divisor; tick period is divisor_i+1 clocks |
| data_bits_i | input | 2 | Character width code (0..3 gives 5..8 bits) |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| rd_data_i | input | 1 | Byte read pulse, clears data_valid_o |
| stat_rd_i | input | 1 | Status read pulse, clears the error flags |
| data_o | output | 8 | Last received character, right-aligned |
| data_valid_o | output | 1 | An unread character is present |
| overrun_o | output | 1 | Sticky overrun flag |
| parity_err_o | output | 1 | Sticky parity error flag |
| frame_err_o | output | 1 | Sticky framing error flag |
| break_o | output | 1 | Sticky break flag |

## Verification
The hardest condition to reach is break, because it needs the line held low past a frame-length count. That count depends on the current format. Along the way the receiver also decodes an all-zero character with a bad stop bit, which the consumer must take first. The bench holds the line low for fourteen bit times in 8N1 mode. It expects the zero byte with a framing error while the line is still low, then checks break_o and its clear. It also checks that an all-zero character with a good stop bit leaves break_o at 0. Overrun is reached by switching off the automatic reader and sending two characters back to back.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OSR   = 16;  // ticks per bit
  localparam int unsigned DW    = 8;   // widest character
  localparam int unsigned FT_W  = 9;   // frame tick count width

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_e;

  // ticks in one full frame: 16 * (start + data + parity + stops)
  function automatic logic [FT_W-1:0] frame_ticks(input logic [1:0] dbits,
                                                  input logic pen,
                                                  input logic stop2);
    logic [3:0] nb;
    nb = 4'd7 + {2'b00, dbits} + {3'b000, pen} + {3'b000, stop2};
    return FT_W'({nb, 4'b0000});
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r9_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic [FT_W-1:0] limit_i,
  input  logic            stat_rd_i,
  output logic            break_o
);
  logic [FT_W-1:0] low_q;
  logic            hit;

  // fires on the tick that takes the low run past one frame
  assign hit = tick_i && !rx_i && (low_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      break_o <= 1'b0;
    end else begin
      if (rx_i)                      low_q <= '0;
      else if (tick_i && ~&low_q)    low_q <= low_q + 1'b1;
      if (hit)                       break_o <= 1'b1;
      else if (stat_rd_i)            break_o <= 1'b0;
    end
  end

  a_r8_break_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_o && !stat_rd_i) |=> break_o);
  a_r6_break_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!break_o && rx_i) |=> !break_o);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [1:0]    dbits_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop2_i,
  input  logic          rd_data_i,
  input  logic          stat_rd_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          overrun_o,
  output logic          perr_o,
  output logic          ferr_o
);
  rx_state_e   st_q;
  logic [3:0]  tcnt_q;
  logic [2:0]  bcnt_q;
  logic [DW-1:0] sh_q;
  logic        par_q, fbad_q, stop_idx_q, rx_prev_q;
  logic        mid, last_bit, done, par_bad, frm_bad;
  logic [DW-1:0] aligned;

  assign mid      = tick_i && (tcnt_q == 4'd15);
  assign last_bit = (bcnt_q == {1'b1, dbits_i});
  assign done     = (st_q == S_STOP) && mid && (!stop2_i || stop_idx_q);
  assign aligned  = sh_q >> (2'd3 - dbits_i);
  assign par_bad  = par_en_i && ((^aligned ^ par_q) != par_odd_i);
  assign frm_bad  = fbad_q || !rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      tcnt_q     <= '0;
      bcnt_q     <= '0;
      sh_q       <= '0;
      par_q      <= 1'b0;
      fbad_q     <= 1'b0;
      stop_idx_q <= 1'b0;
      rx_prev_q  <= 1'b1;
    end else begin
      rx_prev_q <= rx_i;
      unique case (st_q)
        S_IDLE: if (rx_prev_q && !rx_i) begin
          st_q       <= S_START;
          tcnt_q     <= '0;
          fbad_q     <= 1'b0;
          stop_idx_q <= 1'b0;
        end
        S_START: if (tick_i) begin
          tcnt_q <= tcnt_q + 4'd1;
          if (tcnt_q == 4'd7) begin  // half bit: confirm start
            tcnt_q <= '0;
            bcnt_q <= '0;
            st_q   <= rx_i ? S_IDLE : S_DATA;
          end
        end
        S_DATA: if (tick_i) begin
          tcnt_q <= tcnt_q + 4'd1;
          if (mid) begin
            sh_q   <= {rx_i, sh_q[DW-1:1]};
            bcnt_q <= bcnt_q + 3'd1;
            if (last_bit) st_q <= par_en_i ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick_i) begin
          tcnt_q <= tcnt_q + 4'd1;
          if (mid) begin
            par_q <= rx_i;
            st_q  <= S_STOP;
          end
        end
        S_STOP: if (tick_i) begin
          tcnt_q <= tcnt_q + 4'd1;
          if (mid) begin
            if (!rx_i) fbad_q <= 1'b1;
            if (stop2_i && !stop_idx_q) stop_idx_q <= 1'b1;
            else                        st_q <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      if (done)           data_o <= aligned;
      if (done)           valid_o <= 1'b1;
      else if (rd_data_i) valid_o <= 1'b0;
      if (done && valid_o && !rd_data_i) overrun_o <= 1'b1;
      else if (stat_rd_i)                overrun_o <= 1'b0;
      if (done && par_bad)  perr_o <= 1'b1;
      else if (stat_rd_i)   perr_o <= 1'b0;
      if (done && frm_bad)  ferr_o <= 1'b1;
      else if (stat_rd_i)   ferr_o <= 1'b0;
    end
  end

  a_r5_overrun_on_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && valid_o && !rd_data_i) |=> overrun_o);
  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !stat_rd_i) |=> overrun_o);
  a_r8_perr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !done) |=> (!perr_o && !ferr_o && !overrun_o));
  a_r2_valid_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> valid_o);
  a_r8_valid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_data_i) |=> valid_o);
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic             two_stop_i,
  input  logic             rx_i,
  input  logic             rd_data_i,
  input  logic             stat_rd_i,
  output logic [7:0]       data_o,
  output logic             data_valid_o,
  output logic             overrun_o,
  output logic             parity_err_o,
  output logic             frame_err_o,
  output logic             break_o
);
  logic            rx_s, tick;
  logic [FT_W-1:0] ft_limit;

  assign ft_limit = frame_ticks(data_bits_i, parity_en_i, two_stop_i);

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i(divisor_i), .tick_o(tick)
  );

  uart_rx_core u_core (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_s),
    .dbits_i(data_bits_i), .par_en_i(parity_en_i), .par_odd_i(parity_odd_i),
    .stop2_i(two_stop_i), .rd_data_i, .stat_rd_i,
    .data_o, .valid_o(data_valid_o), .overrun_o,
    .perr_o(parity_err_o), .ferr_o(frame_err_o)
  );

  uart_rx_brk u_brk (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_s),
    .limit_i(ft_limit), .stat_rd_i, .break_o
  );
endmodule

// File: tb/uart_rx_err_tb.sv
module uart_rx_err_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic [1:0]  data_bits = 2'd3;
  logic        par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic        rx = 1'b1;
  logic        mon_rd = 1'b0, mon_stat = 1'b0, man_rd = 1'b0, man_stat = 1'b0;
  logic [7:0]  data;
  logic        valid, ovr, perr, ferr, brk;

  uart_rx_err u_dut (
    .clk_i(clk), .rst_ni(rst_n), .divisor_i(divisor), .data_bits_i(data_bits),
    .parity_en_i(par_en), .parity_odd_i(par_odd), .two_stop_i(two_stop),
    .rx_i(rx), .rd_data_i(mon_rd | man_rd), .stat_rd_i(mon_stat | man_stat),
    .data_o(data), .data_valid_o(valid), .overrun_o(ovr),
    .parity_err_o(perr), .frame_err_o(ferr), .break_o(brk)
  );

  typedef struct packed { logic [7:0] d; logic pe; logic fe; } exp_t;
  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0;
  int   bit_clk = 64;
  bit   auto_rd = 1'b1;
  bit   done_flag = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic bit_out(logic v);
    rx = v;
    repeat (bit_clk) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, int nb, bit pen, bit odd, bit two,
                      bit bad_par, bit bad_s1, bit bad_s2, bit push);
    logic [7:0] dm;
    exp_t e;
    dm = d & ((8'h1 << nb) - 8'h1);
    data_bits = 2'(nb - 5);
    par_en = pen; par_odd = odd; two_stop = two;
    if (push) begin
      e.d = dm; e.pe = pen & bad_par; e.fe = bad_s1 | (two & bad_s2);
      exp_q.push_back(e);
    end
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(dm[i]);
    if (pen) bit_out((^dm) ^ odd ^ bad_par);
    bit_out(!bad_s1);
    if (two) bit_out(!bad_s2);
    bit_out(1'b1);
  endtask

  task automatic pulse_stat();
    @(negedge clk) man_stat = 1'b1;
    @(negedge clk) man_stat = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) man_rd = 1'b1;
    @(negedge clk) man_rd = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_rd) begin
        mon_rd = 1'b0; mon_stat = 1'b0;
      end else if (auto_rd && valid) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R2 unexpected byte: actual=%0h expected=none", data);
        end else begin
          e = exp_q.pop_front();
          check("R2", "data", data, e.d);
          check("R3", "parity_err", perr, e.pe);
          check("R4", "frame_err", ferr, e.fe);
          check("R5", "overrun", ovr, 0);
        end
        mon_rd = 1'b1; mon_stat = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "valid", valid, 0);
    check("R1", "flags", {ovr, perr, ferr, brk}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "valid after release", valid, 0);
    check("R1", "flags after release", {ovr, perr, ferr, brk}, 0);

    // R2: all widths, LSB first
    send(8'hA5, 8, 0, 0, 0, 0, 0, 0, 1);
    send(8'h3C, 8, 0, 0, 0, 0, 0, 0, 1);
    send(8'h15, 5, 0, 0, 1, 0, 0, 0, 1);
    send(8'h2B, 6, 0, 0, 0, 0, 0, 0, 1);
    send(8'h6E, 7, 0, 0, 1, 0, 0, 0, 1);

    // R3: parity modes
    send(8'h5A, 8, 1, 0, 0, 0, 0, 0, 1);
    send(8'h5B, 8, 1, 1, 0, 0, 0, 0, 1);
    send(8'h13, 7, 1, 0, 0, 1, 0, 0, 1);
    send(8'h0F, 6, 1, 1, 1, 1, 0, 0, 1);

    // R4: framing errors, single and second stop
    send(8'h81, 8, 0, 0, 0, 0, 1, 0, 1);
    send(8'h42, 8, 0, 0, 1, 0, 0, 1, 1);
    send(8'h1E, 5, 1, 0, 1, 0, 1, 0, 1);

    // R9: other divisors
    divisor = 16'd0; bit_clk = 16;
    repeat (32) @(negedge clk);
    send(8'hC3, 8, 0, 0, 0, 0, 0, 0, 1);
    divisor = 16'd5; bit_clk = 96;
    repeat (32) @(negedge clk);
    send(8'h96, 8, 1, 1, 0, 0, 0, 0, 1);
    divisor = 16'd3; bit_clk = 64;
    repeat (32) @(negedge clk);

    // R7: short low pulse ignored
    data_bits = 2'd3; par_en = 1'b0; two_stop = 1'b0;
    rx = 1'b0; repeat (24) @(negedge clk); rx = 1'b1;
    repeat (3 * bit_clk) @(negedge clk);
    check("R7", "valid after glitch", valid, 0);
    check("R7", "flags after glitch", {ovr, perr, ferr, brk}, 0);
    send(8'h77, 8, 0, 0, 0, 0, 0, 0, 1);

    // R6: all-zero character is not a break
    send(8'h00, 8, 0, 0, 0, 0, 0, 0, 1);
    check("R6", "break after zero byte", brk, 0);

    // R6: line held low for 14 bit times
    exp_q.push_back('{d: 8'h00, pe: 1'b0, fe: 1'b1});
    rx = 1'b0;
    repeat (14 * bit_clk) @(negedge clk);
    check("R6", "break while low", brk, 1);
    rx = 1'b1;
    repeat (2 * bit_clk) @(negedge clk);
    check("R8", "break held", brk, 1);
    pulse_stat();
    check("R8", "break cleared", brk, 0);

    // R5/R8: overrun with reader off
    auto_rd = 1'b0;
    send(8'h11, 8, 0, 0, 0, 0, 0, 0, 0);
    check("R5", "first byte", data, 8'h11);
    check("R5", "no overrun yet", ovr, 0);
    send(8'h22, 8, 0, 0, 0, 0, 0, 0, 0);
    check("R5", "byte replaced", data, 8'h22);
    check("R5", "overrun set", ovr, 1);
    repeat (3 * bit_clk) @(negedge clk);
    check("R8", "overrun sticky", ovr, 1);
    check("R8", "valid held", valid, 1);
    pulse_stat();
    check("R8", "overrun cleared", ovr, 0);
    check("R8", "valid kept by status read", valid, 1);
    pulse_rd();
    check("R8", "valid cleared", valid, 0);
    auto_rd = 1'b1;

    send(8'hE4, 8, 1, 0, 1, 0, 0, 0, 1);
    repeat (bit_clk) @(negedge clk);
    check("R2", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule